// File: doc/BRIEF.md
# Serial SAR Converter Sequencer

This block is the digital control for a two-input, 10-bit successive-approximation converter with a serial read-out. An active-low select line also acts as the shutdown control. While the select line is high, the block keeps the data pin released and the sampler idle. When the select line falls, the block records the serial clock level to choose its conversion clock. A high level selects the internal oscillator and a low level selects the serial clock itself. The block then tracks the input, takes the sample, and runs a 12-step binary search against a one-bit comparator decision.

The search covers the 10 result bits plus two finer sub-LSB bits. When it completes, the block raises the data line as a done flag. Further serial clock falls then shift out the channel number and the full 12-bit code, most significant bit first. After the last bit the data pin is released again. The input multiplexer alternates between the two channels on every select cycle. Two select pulses between conversions therefore repeat the same channel. The analog comparator, the capacitive DAC and the oscillator lie outside the block. Every input is synchronised to the system clock, and every output is driven from registered state.

Top module: `sar_serial_ctrl`

## Requirements
- R1: After reset, `dout_oe`, `track_en` and `osc_en` are 0, and `ch_sel` is 0 (channel 0).
- R2: While the synchronised `cs_n` is high, the block is in shutdown: `dout_oe`, `track_en` and `osc_en` are all 0.
- R3: `ch_sel` flips on every rising edge of `cs_n` and holds at all other times. The first conversion after reset uses channel 0.
- R4: The `sclk` level at the falling edge of `cs_n` fixes the conversion clock for that cycle: 1 selects internal oscillator pacing and 0 selects `sclk` pacing.
- R5: In `sclk`-paced mode, `track_en` is 1 from the `cs_n` fall until the second `sclk` falling edge, where the sample is taken. The 12 search steps happen on `sclk` falls 3 to 14. `dout` becomes 1 at fall 14.
- R6: In oscillator-paced mode, the first `sclk` fall takes the sample and raises `osc_en`. Each `osc_tick` while `osc_en` is 1 performs one search step. After the 12th step, `osc_en` drops and `dout` goes to 1 without waiting for an `sclk` edge.
- R7: The search starts with trial code 0x800 on `dac_code`. At each step, the current trial bit is kept when `cmp_hi` is 1 (input at or above the DAC level) and cleared otherwise, and the next lower bit is set. The final code is the largest code not above the input.
- R8: After the done flag, successive `sclk` falls put on `dout` the channel bit (0 = channel 0, 1 = channel 1), then code bits 11 down to 0. Bits 11..2 are the 10-bit result and bits 1..0 are the sub-LSB bits. The next fall releases `dout_oe`.
- R9: While `cs_n` is low and `dout_oe` is 1, `dout` changes only after an `sclk` falling edge or at the oscillator-paced end of conversion.
- R10: A rise of `cs_n` at any point in a frame aborts the conversion and releases `dout_oe`, `track_en` and `osc_en`. The channel still advances.
- R11: `sclk` falls after the frame has ended leave `dout_oe` at 0 until the next `cs_n` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select, high = shutdown |
| sclk | input | 1 | Serial clock from the host |
| osc_tick | input | 1 | One-cycle pulse from the internal oscillator |
| cmp_hi | input | 1 | Comparator: 1 when input is at or above the DAC level |
| dac_code | output | 12 | Trial code presented to the capacitive DAC |
| track_en | output | 1 | 1 = sampler tracks the input |
| osc_en | output | 1 | Enables the internal oscillator |
| ch_sel | output | 1 | Input multiplexer select (0 or 1) |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Output enable for the data pad, 0 = high impedance |

## Verification
Several properties are checked on every cycle: the quiet shutdown outputs, the channel flip on each select rise and its hold otherwise, and the mutual exclusion of tracking, oscillator run and a high data line. The checker also confirms that the data line moves only after a serial clock fall or an internal end of conversion. Some behaviours can only be shown by the bench scenarios. These are the clock-mode choice, the exact sample edge, the numeric search result against a modelled comparator, the order of the read-out frame, and the channel sequence across aborted and empty select cycles.

// File: rtl/sarc_pkg.sv
package sarc_pkg;
   typedef enum logic [2:0] {
      SARC_SHDN  = 3'd0,
      SARC_TRACK = 3'd1,
      SARC_CONV  = 3'd2,
      SARC_SHIFT = 3'd3,
      SARC_IDLE  = 3'd4
   } sarc_state_e;
endpackage

// File: rtl/sarc_sync.sv
module sarc_sync #(
   parameter int  STAGES  = 2,
   parameter bit  RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic fall,
   output logic rise
);
   logic prev;

   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d} & {STAGES{1'b1}};
         end
         assign q = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= q;
   end

   assign fall = prev & ~q;
   assign rise = ~prev & q;
endmodule

// File: rtl/sarc_search.sv
module sarc_search #(
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              step,
   input  logic              cmp_hi,
   output logic [CODE_W-1:0] code,
   output logic              last
);
   localparam logic [CODE_W-1:0] MSB_ONE = {1'b1, {(CODE_W-1){1'b0}}};

   logic [CODE_W-1:0] ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= '0;
         ptr  <= '0;
      end else if (start) begin
         code <= MSB_ONE;
         ptr  <= MSB_ONE;
      end else if (step) begin
         code <= (cmp_hi ? code : (code & ~ptr)) | (ptr >> 1);
         ptr  <= ptr >> 1;
      end
   end

   assign last = ptr[0];
endmodule

// File: rtl/sarc_frame.sv
module sarc_frame #(
   parameter int CODE_W = 12,
   parameter int IDX_W  = 4
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic              chan,
   input  logic [CODE_W-1:0] code,
   output logic              bit_out
);
   always_comb begin
      int k;
      k = CODE_W + 1 - int'(idx);
      if (idx == '0)                    bit_out = 1'b1;
      else if (idx == IDX_W'(1))        bit_out = chan;
      else if (k >= 0 && k < CODE_W)    bit_out = code[k];
      else                              bit_out = 1'b0;
   end
endmodule

// File: rtl/sar_serial_ctrl.sv
module sar_serial_ctrl
   import sarc_pkg::*;
#(
   parameter int DATA_BITS   = 10,
   parameter int EXTRA_BITS  = 2,
   parameter int SYNC_STAGES = 2,
   parameter int SAMPLE_FALL = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cs_n,
   input  logic                            sclk,
   input  logic                            osc_tick,
   input  logic                            cmp_hi,
   output logic [DATA_BITS+EXTRA_BITS-1:0] dac_code,
   output logic                            track_en,
   output logic                            osc_en,
   output logic                            ch_sel,
   output logic                            dout,
   output logic                            dout_oe
);
   localparam int CODE_W    = DATA_BITS + EXTRA_BITS;
   localparam int FRAME_LEN = CODE_W + 2;
   localparam int IDX_W     = $clog2(FRAME_LEN);
   localparam int FC_W      = $clog2(SAMPLE_FALL + 1);

   generate
      if (DATA_BITS < 2)     begin : g_bad_data  $error("DATA_BITS must be at least 2"); end
      if (EXTRA_BITS < 0)    begin : g_bad_extra $error("EXTRA_BITS must not be negative"); end
      if (SYNC_STAGES < 0)   begin : g_bad_sync  $error("SYNC_STAGES must not be negative"); end
      if (SAMPLE_FALL < 1)   begin : g_bad_samp  $error("SAMPLE_FALL must be at least 1"); end
   endgenerate

   logic cs_s, cs_fall, cs_rise;
   logic sclk_s, sclk_fall, sclk_rise;

   sarc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .d(cs_n),
      .q(cs_s), .fall(cs_fall), .rise(cs_rise)
   );

   sarc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
      .clk(clk), .rst_n(rst_n), .d(sclk),
      .q(sclk_s), .fall(sclk_fall), .rise(sclk_rise)
   );

   sarc_state_e       state;
   logic              mode_int;
   logic [FC_W-1:0]   fall_cnt;
   logic [IDX_W-1:0]  bit_idx;
   logic [IDX_W-1:0]  nxt_idx;
   logic              dout_q;
   logic              ch_ptr;
   logic              ch_conv;

   logic              sar_start;
   logic              sar_step;
   logic              sar_last;
   logic              conv_done;
   logic              nxt_bit;
   logic [CODE_W-1:0] sar_code;

   assign sar_start = (state == SARC_TRACK) && !cs_s && sclk_fall &&
                      (mode_int || (fall_cnt == FC_W'(SAMPLE_FALL - 1)));
   assign sar_step  = (state == SARC_CONV) && !cs_s &&
                      (mode_int ? osc_tick : sclk_fall);
   assign conv_done = sar_step && sar_last;
   assign nxt_idx   = bit_idx + 1'b1;

   sarc_search #(.CODE_W(CODE_W)) u_search (
      .clk(clk), .rst_n(rst_n), .start(sar_start), .step(sar_step),
      .cmp_hi(cmp_hi), .code(sar_code), .last(sar_last)
   );

   sarc_frame #(.CODE_W(CODE_W), .IDX_W(IDX_W)) u_frame (
      .idx(nxt_idx), .chan(ch_conv), .code(sar_code), .bit_out(nxt_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_ptr <= 1'b0;
      end else if (cs_rise) begin
         ch_ptr <= ~ch_ptr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SARC_SHDN;
         mode_int <= 1'b0;
         fall_cnt <= '0;
         bit_idx  <= '0;
         dout_q   <= 1'b0;
         ch_conv  <= 1'b0;
      end else if (cs_s) begin
         state    <= SARC_SHDN;
         dout_q   <= 1'b0;
      end else begin
         case (state)
            SARC_SHDN: begin
               if (cs_fall) begin
                  state    <= SARC_TRACK;
                  mode_int <= sclk_s;
                  fall_cnt <= '0;
                  dout_q   <= 1'b0;
                  ch_conv  <= ch_ptr;
               end
            end
            SARC_TRACK: begin
               if (sar_start)      state    <= SARC_CONV;
               else if (sclk_fall) fall_cnt <= fall_cnt + 1'b1;
            end
            SARC_CONV: begin
               if (conv_done) begin
                  state   <= SARC_SHIFT;
                  dout_q  <= 1'b1;
                  bit_idx <= '0;
               end
            end
            SARC_SHIFT: begin
               if (sclk_fall) begin
                  if (bit_idx == IDX_W'(FRAME_LEN - 1)) begin
                     state  <= SARC_IDLE;
                     dout_q <= 1'b0;
                  end else begin
                     bit_idx <= nxt_idx;
                     dout_q  <= nxt_bit;
                  end
               end
            end
            default: begin
               state <= SARC_IDLE;
            end
         endcase
      end
   end

   assign dac_code = sar_code;
   assign track_en = (state == SARC_TRACK);
   assign osc_en   = (state == SARC_CONV) && mode_int;
   assign ch_sel   = ch_ptr;
   assign dout     = dout_q;
   assign dout_oe  = (state == SARC_TRACK) || (state == SARC_CONV) ||
                     (state == SARC_SHIFT);
endmodule

// File: rtl/sarc_chk.sv
module sarc_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_s,
   input logic cs_rise,
   input logic sclk_fall,
   input logic conv_done,
   input logic track_en,
   input logic osc_en,
   input logic ch_sel,
   input logic dout,
   input logic dout_oe
);
   // R2
   shdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> (!dout_oe && !track_en && !osc_en));

   // R3
   ch_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> (ch_sel != $past(ch_sel)));

   // R3
   ch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_rise |=> $stable(ch_sel));

   // R5
   track_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      track_en |-> (!osc_en && dout_oe && !dout));

   // R6
   osc_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      osc_en |-> (dout_oe && !dout && !track_en));

   // R9
   dout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclk_fall && !conv_done && !cs_s) |=> ($stable(dout) || !dout_oe));
endmodule

bind sar_serial_ctrl sarc_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_rise(cs_rise),
   .sclk_fall(sclk_fall), .conv_done(conv_done), .track_en(track_en),
   .osc_en(osc_en), .ch_sel(ch_sel), .dout(dout), .dout_oe(dout_oe)
);

// File: tb/sar_serial_ctrl_tb.sv
`timescale 1ns/1ps
module sar_serial_ctrl_tb;
   localparam int HALF = 8;
   localparam int TICK = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b0;
   logic        osc_tick = 1'b0;
   logic        cmp_hi;
   logic [11:0] dac_code;
   logic        track_en, osc_en, ch_sel, dout, dout_oe;
   logic [11:0] vin = '0;
   logic        exp_ch = 1'b0;
   logic        finished = 1'b0;
   int          checks = 0;
   int          fails = 0;

   always #4 clk = ~clk;

   assign cmp_hi = (vin >= dac_code);

   sar_serial_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .osc_tick(osc_tick),
      .cmp_hi(cmp_hi), .dac_code(dac_code), .track_en(track_en), .osc_en(osc_en),
      .ch_sel(ch_sel), .dout(dout), .dout_oe(dout_oe)
   );

   initial begin
      forever begin
         repeat (TICK - 1) @(negedge clk);
         osc_tick = 1'b1;
         @(negedge clk);
         osc_tick = 1'b0;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sclk_pulse();
      sclk = 1'b1; wait_clk(HALF);
      sclk = 1'b0; wait_clk(HALF);
   endtask

   task automatic cs_start(input bit lvl);
      sclk = lvl; wait_clk(HALF);
      cs_n = 1'b0; wait_clk(HALF);
   endtask

   task automatic cs_end();
      cs_n = 1'b1; wait_clk(HALF);
      exp_ch = ~exp_ch;
      chk(dout_oe == 1'b0 && track_en == 1'b0 && osc_en == 1'b0, "R2 shutdown outputs",
          {dout_oe, track_en, osc_en}, 0);
      chk(ch_sel == exp_ch, "R3 channel advance", ch_sel, exp_ch);
   endtask

   task automatic read_frame(input logic [11:0] code);
      logic [12:0] bits;
      logic        prev;
      bits = {exp_ch, code};
      prev = 1'b1;
      for (int i = 12; i >= 0; i--) begin
         sclk = 1'b1; wait_clk(HALF);
         chk(dout == prev && dout_oe, "R9 dout held during sclk high", dout, prev);
         sclk = 1'b0; wait_clk(HALF);
         chk(dout == bits[i] && dout_oe, "R8 frame bit", {i, dout}, {i, bits[i]});
         prev = bits[i];
      end
      sclk_pulse();
      chk(dout_oe == 1'b0, "R8 release after last bit", dout_oe, 0);
      sclk_pulse();
      chk(dout_oe == 1'b0, "R11 extra falls ignored", dout_oe, 0);
   endtask

   task automatic t_reset();
      chk(dout_oe == 0 && track_en == 0 && osc_en == 0, "R1 reset outputs",
          {dout_oe, track_en, osc_en}, 0);
      chk(ch_sel == 1'b0, "R1 reset channel", ch_sel, 0);
   endtask

   task automatic t_external(input logic [11:0] v);
      vin = v;
      cs_start(1'b0);
      chk(track_en == 1 && dout_oe == 1 && dout == 0, "R5 tracking after select", track_en, 1);
      chk(ch_sel == exp_ch, "R3 channel in use", ch_sel, exp_ch);
      sclk_pulse();
      chk(track_en == 1 && osc_en == 0, "R4 external mode still tracks", track_en, 1);
      sclk_pulse();
      chk(track_en == 0, "R5 sample at second fall", track_en, 0);
      chk(dac_code == 12'h800, "R7 first trial code", dac_code, 12'h800);
      for (int f = 3; f <= 13; f++) sclk_pulse();
      chk(dout == 0, "R5 no done flag before fall 14", dout, 0);
      sclk_pulse();
      chk(dout == 1 && dout_oe == 1, "R5 done flag at fall 14", dout, 1);
      chk(dac_code == v, "R7 final code", dac_code, v);
      read_frame(v);
      cs_end();
   endtask

   task automatic t_internal(input logic [11:0] v);
      vin = v;
      cs_start(1'b1);
      chk(track_en == 1 && osc_en == 0, "R6 tracking before first fall", osc_en, 0);
      sclk = 1'b0; wait_clk(6);
      chk(osc_en == 1 && track_en == 0, "R4 internal mode starts oscillator", osc_en, 1);
      wait_clk(14 * TICK);
      chk(osc_en == 0 && dout == 1 && dout_oe == 1, "R6 end of conversion flag",
          {osc_en, dout, dout_oe}, 3'b011);
      chk(dac_code == v, "R7 internal final code", dac_code, v);
      read_frame(v);
      cs_end();
   endtask

   task automatic t_abort();
      vin = 12'h555;
      cs_start(1'b0);
      for (int f = 1; f <= 5; f++) sclk_pulse();
      chk(dout_oe == 1 && track_en == 0, "R10 converting before abort", dout_oe, 1);
      cs_end();
      chk(dout_oe == 0, "R10 aborted frame released", dout_oe, 0);
   endtask

   task automatic t_empty_cycle();
      cs_start(1'b0);
      cs_end();
   endtask

   initial begin
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(4);
      t_reset();
      t_external(12'hA5C);
      t_internal(12'h3FF);
      t_abort();
      t_external(12'hFFF);
      t_empty_cycle();
      t_external(12'h000);
      t_internal(12'h801);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule